// File: doc/BRIEF.md
# Fixed-Point Vector Post-Processor

This block sits behind a matrix engine and transforms a stream of signed Q8.8 elements, one per cycle. A 4-bit configuration word selects the operating mode. Each mode enables a fixed subset of four chained stages, always in this order:

1. Bias add.
2. Leaky-ReLU activation with a programmable leak factor.
3. Mean-squared-error loss gradient, using a precomputed 2/N scale.
4. Activation derivative, which multiplies an incoming gradient by the slope of the activation.

Each element arrives with its own bias, target and gradient operands, alongside a valid flag. The leak factor and the loss scale are shared by the whole stream.

An enabled stage adds exactly one register. A disabled stage is a straight wire. The output valid therefore follows the input valid after the number of enabled stages. The four decoded modes are:

- MODE_PASS (code 0000, and every unlisted code): no stage enabled.
- MODE_DERIV (0001): derivative stage only.
- MODE_HIDDEN (1100): bias add, then activation.
- MODE_FINAL (1111): bias add, then activation, then loss.

The mapping from code to mode is a pure decode. It has no transitions of its own. The mode changes only when the configuration input changes.

Top module: `vecpost_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid` is 0 in every mode except MODE_PASS.
- R2: With code 0000 (MODE_PASS), `out_valid` and `out_data` equal `in_valid` and `in_data` in the same cycle, with zero latency.
- R3: Every product is formed at full width. It is then shifted right arithmetically by 8, so it rounds toward minus infinity. The result is then saturated to the range 0x8000..0x7FFF.
- R4: With code 1100 (MODE_HIDDEN), the output is the leaky ReLU of (`in_data` + `in_bias`). It appears 2 cycles after the input.
- R5: The activation passes a non-negative value (sign bit 0) unchanged. It multiplies a negative value by `leak_factor` in Q8.8. A leak factor of 0x0000 gives plain ReLU, 0x0080 halves the value and 0x0019 scales it by about 0.1.
- R6: With code 1111 (MODE_FINAL), the output is (activated value − `in_target`), saturated, then multiplied by `loss_scale`. It appears 3 cycles after the input. A scale of 0x0080 corresponds to a batch of 4 and 0x0010 to a batch of 32.
- R7: With code 0001 (MODE_DERIV), the output is `in_grad` × 0x0100 when `in_data` is strictly positive, and `in_grad` × `leak_factor` otherwise, zero included. It appears 1 cycle after the input.
- R8: `out_valid` repeats the `in_valid` pattern, delayed by the mode's latency. Back-to-back elements come out on consecutive cycles, and idle input cycles produce no output.
- R9: Configuration codes other than 0000, 0001, 1100 and 1111 behave exactly as MODE_PASS.
- R10: The bias add saturates: a sum above 0x7FFF gives 0x7FFF, and a sum below 0x8000 gives 0x8000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 4 | Stage-selection code |
| leak_factor | input | 16 | Q8.8 slope for negative activations |
| loss_scale | input | 16 | Q8.8 loss scale, 2/batch size |
| in_valid | input | 1 | Input element valid |
| in_data | input | 16 | Q8.8 element (pre-activation value in MODE_DERIV) |
| in_bias | input | 16 | Q8.8 bias for this element |
| in_target | input | 16 | Q8.8 target for this element |
| in_grad | input | 16 | Q8.8 incoming gradient for this element |
| out_valid | output | 1 | Output element valid |
| out_data | output | 16 | Q8.8 result |

## Verification
Each mode is driven with single elements, covering the following:

- Positive, negative and zero activation inputs, which separate the pass path, the leak path and the strict-positive test of the derivative.
- Three leak factors, which distinguish plain ReLU from the scaled slopes.
- Operands chosen to overflow the sum, the difference and the product. These show that each result clamps rather than wraps.
- A tiny negative gradient, which reveals whether the product rounds toward minus infinity.
- An unlisted code, which must look identical to bypass.
- A back-to-back pair followed by idle cycles, which checks that the valid pattern is delayed intact.

// File: rtl/vpp_pkg.sv
package vpp_pkg;
    localparam int FXW  = 16;
    localparam int FRAC = 8;
    localparam int WIDE = 2 * FXW + 1;
    localparam int NSTG = 4;

    // stage indices, also the chain order
    localparam int STG_BIAS  = 0;
    localparam int STG_ACT   = 1;
    localparam int STG_LOSS  = 2;
    localparam int STG_DERIV = 3;

    typedef logic signed [FXW-1:0] fx_t;

    typedef enum logic [1:0] {
        MODE_PASS,
        MODE_DERIV,
        MODE_HIDDEN,
        MODE_FINAL
    } mode_e;

    typedef struct packed {
        logic valid;
        fx_t  data;
        fx_t  bias;
        fx_t  target;
        fx_t  grad;
    } lane_t;

    function automatic fx_t sat_w(input logic signed [WIDE-1:0] v);
        if (v[WIDE-1:FXW-1] == {(WIDE-FXW+1){v[WIDE-1]}})
            return v[FXW-1:0];
        else if (v[WIDE-1])
            return {1'b1, {(FXW-1){1'b0}}};
        else
            return {1'b0, {(FXW-1){1'b1}}};
    endfunction

    function automatic fx_t sat_add(input fx_t a, input fx_t b);
        logic signed [WIDE-1:0] s;
        s = WIDE'(a) + WIDE'(b);
        return sat_w(s);
    endfunction

    function automatic fx_t sat_sub(input fx_t a, input fx_t b);
        logic signed [WIDE-1:0] s;
        s = WIDE'(a) - WIDE'(b);
        return sat_w(s);
    endfunction

    function automatic fx_t qmul(input fx_t a, input fx_t b);
        logic signed [WIDE-1:0] p;
        p = WIDE'(a) * WIDE'(b);
        return sat_w(p >>> FRAC);
    endfunction
endpackage

// File: rtl/vpp_mode_decode.sv
module vpp_mode_decode
    import vpp_pkg::*;
(
    input  logic [3:0]      cfg,
    output mode_e           mode,
    output logic [NSTG-1:0] stage_en
);
    // code to mode; every unlisted code folds into MODE_PASS
    always_comb begin
        case (cfg)
            4'b0001: mode = MODE_DERIV;
            4'b1100: mode = MODE_HIDDEN;
            4'b1111: mode = MODE_FINAL;
            default: mode = MODE_PASS;
        endcase
    end

    // mode to stage enables
    always_comb begin
        stage_en = '0;
        unique case (mode)
            MODE_PASS:   stage_en = '0;
            MODE_DERIV:  stage_en[STG_DERIV] = 1'b1;
            MODE_HIDDEN: begin
                stage_en[STG_BIAS] = 1'b1;
                stage_en[STG_ACT]  = 1'b1;
            end
            MODE_FINAL: begin
                stage_en[STG_BIAS] = 1'b1;
                stage_en[STG_ACT]  = 1'b1;
                stage_en[STG_LOSS] = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/vpp_stage.sv
module vpp_stage
    import vpp_pkg::*;
#(
    parameter int KIND = STG_BIAS
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  fx_t   leak,
    input  fx_t   scale,
    input  lane_t in_l,
    output lane_t out_l
);
    localparam fx_t ONE = fx_t'(1 << FRAC);

    fx_t   op_val;
    lane_t res;
    lane_t held;

    always_comb begin
        unique case (KIND)
            STG_BIAS:  op_val = sat_add(in_l.data, in_l.bias);
            STG_ACT:   op_val = in_l.data[FXW-1] ? qmul(in_l.data, leak) : in_l.data;
            STG_LOSS:  op_val = qmul(sat_sub(in_l.data, in_l.target), scale);
            default:   op_val = qmul(in_l.grad,
                                     (!in_l.data[FXW-1] && (|in_l.data)) ? ONE : leak);
        endcase
        res      = in_l;
        res.data = op_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) held <= '0;
        else        held <= res;
    end

    assign out_l = en ? held : in_l;

    // R8
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && en && $past(en)) |-> (out_l.valid == $past(in_l.valid)));

    if (KIND == STG_ACT) begin : g_act_chk
        // R5
        nonneg_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && en && $past(en) && $past(in_l.valid) && !$past(in_l.data[FXW-1]))
            |-> (out_l.data == $past(in_l.data)));
    end

    if (KIND == STG_DERIV) begin : g_deriv_chk
        // R7
        deriv_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && en && $past(en) && $past(in_l.valid)
             && !$past(in_l.data[FXW-1]) && ($past(in_l.data) != '0))
            |-> (out_l.data == $past(in_l.grad)));
    end
endmodule

// File: rtl/vecpost_top.sv
module vecpost_top
    import vpp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  cfg_mode,
    input  logic [15:0] leak_factor,
    input  logic [15:0] loss_scale,
    input  logic        in_valid,
    input  logic [15:0] in_data,
    input  logic [15:0] in_bias,
    input  logic [15:0] in_target,
    input  logic [15:0] in_grad,
    output logic        out_valid,
    output logic [15:0] out_data
);
    mode_e           mode;
    logic [NSTG-1:0] stage_en;
    lane_t           lanes [NSTG+1];
    logic            unused_tail;

    vpp_mode_decode i_decode (
        .cfg      (cfg_mode),
        .mode     (mode),
        .stage_en (stage_en)
    );

    assign lanes[0] = '{valid: in_valid, data: in_data, bias: in_bias,
                        target: in_target, grad: in_grad};

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        vpp_stage #(.KIND(s)) i_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (stage_en[s]),
            .leak  (leak_factor),
            .scale (loss_scale),
            .in_l  (lanes[s]),
            .out_l (lanes[s+1])
        );
    end

    assign out_valid   = lanes[NSTG].valid;
    assign out_data    = lanes[NSTG].data;
    assign unused_tail = ^{lanes[NSTG].bias, lanes[NSTG].target, lanes[NSTG].grad};

    // R2
    bypass_wire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 4'b0000) |-> (out_valid == in_valid && out_data == in_data));

    // R9
    unlisted_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode != 4'b0000 && cfg_mode != 4'b0001 && cfg_mode != 4'b1100 && cfg_mode != 4'b1111)
        |-> (stage_en == '0 && out_valid == in_valid && out_data == in_data));
endmodule

// File: tb/test_vecpost_top.sv
module test_vecpost_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cfg_mode = '0;
    logic [15:0] leak_factor = '0, loss_scale = '0;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0, in_bias = '0, in_target = '0, in_grad = '0;
    logic        out_valid;
    logic [15:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vecpost_top i_vecpost_top (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .leak_factor(leak_factor),
        .loss_scale(loss_scale), .in_valid(in_valid), .in_data(in_data), .in_bias(in_bias),
        .in_target(in_target), .in_grad(in_grad), .out_valid(out_valid), .out_data(out_data)
    );

    typedef struct packed {
        logic [3:0]  cfg;
        logic [15:0] leak, scale, x, b, t, g, exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'b0000, 16'h0000, 16'h0000, 16'h1234, 16'h0000, 16'h0000, 16'h0000, 16'h1234, 8'd2},  // R2
        '{4'b0101, 16'h0000, 16'h0000, 16'hF000, 16'h0100, 16'h0000, 16'h0000, 16'hF000, 8'd9},  // R9
        '{4'b1100, 16'h0080, 16'h0000, 16'h0200, 16'h0100, 16'h0000, 16'h0000, 16'h0300, 8'd4},  // R4
        '{4'b1100, 16'h0080, 16'h0000, 16'hFC00, 16'h0000, 16'h0000, 16'h0000, 16'hFE00, 8'd5},  // R5
        '{4'b1100, 16'h0000, 16'h0000, 16'hFE00, 16'h0100, 16'h0000, 16'h0000, 16'h0000, 8'd5},  // R5
        '{4'b1100, 16'h0019, 16'h0000, 16'hF600, 16'h0000, 16'h0000, 16'h0000, 16'hFF06, 8'd5},  // R5
        '{4'b1100, 16'h0080, 16'h0000, 16'h7F00, 16'h0200, 16'h0000, 16'h0000, 16'h7FFF, 8'd10}, // R10
        '{4'b1100, 16'h0080, 16'h0000, 16'h8100, 16'hFE00, 16'h0000, 16'h0000, 16'hC000, 8'd10}, // R10
        '{4'b1111, 16'h0080, 16'h0080, 16'h0300, 16'h0100, 16'h0200, 16'h0000, 16'h0100, 8'd6},  // R6
        '{4'b1111, 16'h0080, 16'h0010, 16'h0000, 16'h0000, 16'h0400, 16'h0000, 16'hFFC0, 8'd6},  // R6
        '{4'b0001, 16'h0080, 16'h0000, 16'h0100, 16'h0000, 16'h0000, 16'h0300, 16'h0300, 8'd7},  // R7
        '{4'b0001, 16'h0080, 16'h0000, 16'hFF00, 16'h0000, 16'h0000, 16'h0300, 16'h0180, 8'd7},  // R7
        '{4'b0001, 16'h0019, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0400, 16'h0064, 8'd7},  // R7
        '{4'b1100, 16'h0400, 16'h0000, 16'hC000, 16'h0000, 16'h0000, 16'h0000, 16'h8000, 8'd3},  // R3
        '{4'b1111, 16'h0080, 16'h0200, 16'h4000, 16'h0000, 16'hC000, 16'h0000, 16'h7FFF, 8'd3},  // R3
        '{4'b0001, 16'h0080, 16'h0000, 16'hFF00, 16'h0000, 16'h0000, 16'hFFFF, 16'hFFFF, 8'd3}   // R3
    };

    function automatic int lat_of(input logic [3:0] c);
        case (c)
            4'b0001: return 1;
            4'b1100: return 2;
            4'b1111: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        // R1: reset state in a registered mode
        cfg_mode = 4'b1100;
        repeat (3) @(negedge clk);
        check("R1 reset", {15'd0, out_valid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 post-reset", {15'd0, out_valid}, 16'd0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            int lat;
            string tag;
            lat = lat_of(VECS[i].cfg);
            tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
            @(negedge clk);
            cfg_mode    = VECS[i].cfg;
            leak_factor = VECS[i].leak;
            loss_scale  = VECS[i].scale;
            in_data     = VECS[i].x;
            in_bias     = VECS[i].b;
            in_target   = VECS[i].t;
            in_grad     = VECS[i].g;
            in_valid    = 1'b1;
            if (lat == 0) begin
                #1;
                check(tag, {15'd0, out_valid}, 16'd1);
                check(tag, out_data, VECS[i].exp);
                @(negedge clk);
                in_valid = 1'b0;
            end else begin
                @(negedge clk);
                in_valid = 1'b0;
                for (int k = 1; k < lat; k++) @(negedge clk);
                check(tag, {15'd0, out_valid}, 16'd1);
                check(tag, out_data, VECS[i].exp);
            end
            @(negedge clk);
        end

        // R8: back-to-back pair in MODE_HIDDEN, then idle
        cfg_mode    = 4'b1100;
        leak_factor = 16'h0080;
        in_bias     = 16'h0000;
        @(negedge clk);
        in_valid = 1'b1; in_data = 16'h0100;
        @(negedge clk);
        in_data = 16'hFF00;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 first valid", {15'd0, out_valid}, 16'd1);
        check("R8 first data", out_data, 16'h0100);
        @(negedge clk);
        check("R8 second valid", {15'd0, out_valid}, 16'd1);
        check("R8 second data", out_data, 16'hFF80);
        @(negedge clk);
        check("R8 idle", {15'd0, out_valid}, 16'd0);
        @(negedge clk);
        check("R8 idle", {15'd0, out_valid}, 16'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule